// File: doc/BRIEF.md
# Watchpoint Address Register Bank

This block keeps the address operands of a processor debug unit's data watchpoints: sixteen 64-bit registers, reached through the core's system-register access path. Each request carries a five-field selector, a direction flag, write data, the requester's privilege level and a set of trap and debug-control inputs. In the same cycle, the block decodes the selector and runs a fixed-priority permission check. It then reports one outcome: not addressed, accepted, undefined, trap to level 2, trap to level 3, or debug halt.

An accepted read returns the stored address in the same cycle. The two low bits are forced to zero, and everything above the top address bit is a copy of that bit. An accepted write takes effect at the next rising clock edge. Only the address field is kept, so bits written to the reserved positions are dropped.

A parameter chooses whether the address field reaches bit 52 or stops at bit 48. A cold reset clears the bank. A warm reset input exists but never touches the stored values.

Top module: `wpt_addr_bank`

## Requirements
- R1: A request is addressed to the bank only when `req_valid` is 1, `sel_op0`=2, `sel_op1`=0, `sel_crn`=0, `sel_op2`=6 and `sel_crm` is below the register count; `sel_crm` picks the register. Any other request reports `status`=0 (none) and changes no register.
- R2: An addressed request from level 0 (`cur_el`=0) reports `status`=2 (undefined), whatever the trap inputs are.
- R3: From level 1, `status`=3 (trap to level 2) is reported when `el2_enabled`, `el2_is64` and at least one of `l2_trap_dbg_all`/`l2_trap_dbg_reg` are 1. This check outranks R4 and R5.
- R4: From level 1 (when R3 does not apply) or from level 2, `status`=4 (trap to level 3) is reported when `el3_present`, `el3_is64` and `l3_trap_dbg_reg` are 1. Both trap codes drive `exc_class`=0x18; every other outcome drives `exc_class`=0.
- R5: From levels 1 to 3, when no trap applies, `status`=5 (debug halt) is reported when `el1_is64`=1, `os_lock`=0, `halt_allowed`=1 and `ext_trap_dbg`=1.
- R6: Otherwise the outcome is `status`=1 (accepted). A read returns the formatted register in the same cycle. A write stores `wdata` into the register picked by `sel_crm` at the next rising edge.
- R7: Bits [1:0] of read data are always 0. Written values in those bits are ignored.
- R8: The address field is bits [52:2] when `LARGE_VA`=1 (default) and bits [48:2] otherwise. Every read-data bit above the field equals the field's top bit, and written values above the field are ignored.
- R9: No outcome other than accepted changes any register, and `rdata` is 0 unless the outcome is an accepted read.
- R10: A cold reset (`cold_rst_n` low) clears every register to 0. `warm_rst_n` has no effect on stored values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| cold_rst_n | input | 1 | Cold reset, active low, asynchronous |
| warm_rst_n | input | 1 | Warm reset, active low, no effect on storage |
| req_valid | input | 1 | Access request present |
| req_write | input | 1 | 1 = write, 0 = read |
| sel_op0 | input | 2 | Selector field op0 |
| sel_op1 | input | 3 | Selector field op1 |
| sel_crn | input | 4 | Selector field CRn |
| sel_crm | input | 4 | Selector field CRm, register index |
| sel_op2 | input | 3 | Selector field op2 |
| wdata | input | 64 | Write data |
| cur_el | input | 2 | Privilege level of the requester |
| el2_enabled | input | 1 | Level 2 is enabled |
| el2_is64 | input | 1 | Level 2 runs 64-bit |
| l2_trap_dbg_all | input | 1 | Level-2 route-all-debug trap enable |
| l2_trap_dbg_reg | input | 1 | Level-2 debug-register trap enable |
| el3_present | input | 1 | Level 3 is implemented |
| el3_is64 | input | 1 | Level 3 runs 64-bit |
| l3_trap_dbg_reg | input | 1 | Level-3 debug-register trap enable |
| el1_is64 | input | 1 | Level 1 runs 64-bit |
| os_lock | input | 1 | OS lock is set |
| halt_allowed | input | 1 | Halting is currently allowed |
| ext_trap_dbg | input | 1 | External debugger traps debug-register access |
| status | output | 3 | Outcome: 0 none, 1 ok, 2 undefined, 3 trap L2, 4 trap L3, 5 halt |
| exc_class | output | 6 | Exception class for trap outcomes |
| rdata | output | 64 | Read data |

## Verification
Two things can share one cycle. The first is a write that the permission logic rejects, followed at once by a read of the same register. The second is a permission check in which several trap and halt conditions are true together. The bench provokes the first by following each faulted write with a read of its target. It provokes the second with directed runs that raise every condition at each privilege level and with a long pseudo-random sweep over all control inputs. A behavioural model works out the winning outcome and the stored value separately for every cycle. Cold-reset and warm-reset pulses are placed between accesses, so stored state can only be seen after a reset through the normal read path.

// File: rtl/wpt_addr_bank.sv
`timescale 1ns/1ps
module wpt_addr_bank #(
  parameter int NUM_WP   = 16,
  parameter int XLEN     = 64,
  parameter bit LARGE_VA = 1'b1
) (
  input  logic            clk,
  input  logic            cold_rst_n,
  input  logic            warm_rst_n,
  input  logic            req_valid,
  input  logic            req_write,
  input  logic [1:0]      sel_op0,
  input  logic [2:0]      sel_op1,
  input  logic [3:0]      sel_crn,
  input  logic [3:0]      sel_crm,
  input  logic [2:0]      sel_op2,
  input  logic [XLEN-1:0] wdata,
  input  logic [1:0]      cur_el,
  input  logic            el2_enabled,
  input  logic            el2_is64,
  input  logic            l2_trap_dbg_all,
  input  logic            l2_trap_dbg_reg,
  input  logic            el3_present,
  input  logic            el3_is64,
  input  logic            l3_trap_dbg_reg,
  input  logic            el1_is64,
  input  logic            os_lock,
  input  logic            halt_allowed,
  input  logic            ext_trap_dbg,
  output logic [2:0]      status,
  output logic [5:0]      exc_class,
  output logic [XLEN-1:0] rdata
);
  localparam int VA_MSB = LARGE_VA ? 52 : 48;
  localparam int FLD_W  = VA_MSB - 1;
  localparam int EXT_W  = XLEN - 1 - VA_MSB;
  localparam int IDX_W  = (NUM_WP > 1) ? $clog2(NUM_WP) : 1;

  localparam logic [2:0] ST_NONE = 3'd0, ST_OK = 3'd1, ST_UNDEF = 3'd2,
                         ST_TRAP2 = 3'd3, ST_TRAP3 = 3'd4, ST_HALT = 3'd5;

  logic [FLD_W-1:0] va_q [NUM_WP];
  logic             sel_hit;
  logic [IDX_W-1:0] idx;
  logic [FLD_W-1:0] cur_va;

  assign sel_hit = req_valid && sel_op0 == 2'b10 && sel_op1 == 3'b000 &&
                   sel_crn == 4'b0000 && sel_op2 == 3'b110 &&
                   ({28'd0, sel_crm} < NUM_WP);
  assign idx     = sel_crm[IDX_W-1:0];
  assign cur_va  = va_q[idx];

  always_comb begin
    if (!sel_hit)
      status = ST_NONE;
    else if (cur_el == 2'd0)
      status = ST_UNDEF;
    else if (cur_el == 2'd1 && el2_enabled && el2_is64 &&
             (l2_trap_dbg_all || l2_trap_dbg_reg))
      status = ST_TRAP2;
    else if ((cur_el == 2'd1 || cur_el == 2'd2) && el3_present && el3_is64 &&
             l3_trap_dbg_reg)
      status = ST_TRAP3;
    else if (el1_is64 && !os_lock && halt_allowed && ext_trap_dbg)
      status = ST_HALT;
    else
      status = ST_OK;
  end

  assign exc_class = (status == ST_TRAP2 || status == ST_TRAP3) ? 6'h18 : 6'h00;
  assign rdata     = (status == ST_OK && !req_write) ?
                     {{EXT_W{cur_va[FLD_W-1]}}, cur_va, 2'b00} : '0;

  always_ff @(posedge clk or negedge cold_rst_n) begin
    if (!cold_rst_n) begin
      for (int i = 0; i < NUM_WP; i++) va_q[i] <= '0;
    end else if (status == ST_OK && req_write) begin
      va_q[idx] <= wdata[VA_MSB:2];
    end
  end

  wire unused_inputs = ^{warm_rst_n, wdata[XLEN-1:VA_MSB+1], wdata[1:0], sel_crm};
endmodule

// File: rtl/wpt_addr_bank_chk.sv
`timescale 1ns/1ps
module wpt_addr_bank_chk #(
  parameter int XLEN   = 64,
  parameter int VA_MSB = 52
) (
  input logic            clk,
  input logic            cold_rst_n,
  input logic            req_valid,
  input logic            req_write,
  input logic [1:0]      cur_el,
  input logic [2:0]      status,
  input logic [5:0]      exc_class,
  input logic [XLEN-1:0] rdata
);
  localparam int EXT_W = XLEN - 1 - VA_MSB;

  a_r1_idle_none: assert property (@(posedge clk) disable iff (!cold_rst_n)
    !req_valid |-> status == 3'd0);
  a_r2_el0_undef: assert property (@(posedge clk) disable iff (!cold_rst_n)
    (status != 3'd0 && cur_el == 2'd0) |-> status == 3'd2);
  a_r3_trap2_from_el1: assert property (@(posedge clk) disable iff (!cold_rst_n)
    status == 3'd3 |-> cur_el == 2'd1);
  a_r4_trap3_level: assert property (@(posedge clk) disable iff (!cold_rst_n)
    status == 3'd4 |-> (cur_el == 2'd1 || cur_el == 2'd2));
  a_r4_trap_class: assert property (@(posedge clk) disable iff (!cold_rst_n)
    (status == 3'd3 || status == 3'd4) |-> exc_class == 6'h18);
  a_r4_no_class: assert property (@(posedge clk) disable iff (!cold_rst_n)
    !(status == 3'd3 || status == 3'd4) |-> exc_class == 6'h00);
  a_r5_r6_code_range: assert property (@(posedge clk) disable iff (!cold_rst_n)
    status <= 3'd5);
  a_r7_low_zero: assert property (@(posedge clk) disable iff (!cold_rst_n)
    rdata[1:0] == 2'b00);
  a_r8_sign_copy: assert property (@(posedge clk) disable iff (!cold_rst_n)
    rdata[VA_MSB] |-> $countones(rdata[XLEN-1:VA_MSB+1]) == EXT_W);
  a_r8_sign_clear: assert property (@(posedge clk) disable iff (!cold_rst_n)
    !rdata[VA_MSB] |-> $countones(rdata[XLEN-1:VA_MSB+1]) == 0);
  a_r9_quiet_rdata: assert property (@(posedge clk) disable iff (!cold_rst_n)
    (status != 3'd1 || req_write) |-> rdata == '0);
endmodule

bind wpt_addr_bank wpt_addr_bank_chk #(.XLEN(XLEN), .VA_MSB(VA_MSB)) u_chk (
  .clk(clk), .cold_rst_n(cold_rst_n), .req_valid(req_valid), .req_write(req_write),
  .cur_el(cur_el), .status(status), .exc_class(exc_class), .rdata(rdata));

// File: tb/test_wpt_addr_bank.sv
`timescale 1ns/1ps
module test_wpt_addr_bank;
  localparam int MSB = 52;

  logic clk = 0, cold_rst_n = 0, warm_rst_n = 1;
  logic req_valid = 0, req_write = 0;
  logic [1:0] sel_op0 = 2; logic [2:0] sel_op1 = 0; logic [3:0] sel_crn = 0;
  logic [3:0] sel_crm = 0; logic [2:0] sel_op2 = 6;
  logic [63:0] wdata = 0;
  logic [1:0] cur_el = 1;
  logic el2_enabled = 0, el2_is64 = 0, l2_all = 0, l2_reg = 0;
  logic el3_present = 0, el3_is64 = 0, l3_reg = 0;
  logic el1_is64 = 0, os_lock = 0, halt_allowed = 0, ext_trap = 0;
  logic [2:0] status; logic [5:0] exc_class; logic [63:0] rdata;

  logic [63:0] mdl [16];
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  wpt_addr_bank i_wpt_addr_bank (
    .clk(clk), .cold_rst_n(cold_rst_n), .warm_rst_n(warm_rst_n),
    .req_valid(req_valid), .req_write(req_write),
    .sel_op0(sel_op0), .sel_op1(sel_op1), .sel_crn(sel_crn), .sel_crm(sel_crm),
    .sel_op2(sel_op2), .wdata(wdata), .cur_el(cur_el),
    .el2_enabled(el2_enabled), .el2_is64(el2_is64),
    .l2_trap_dbg_all(l2_all), .l2_trap_dbg_reg(l2_reg),
    .el3_present(el3_present), .el3_is64(el3_is64), .l3_trap_dbg_reg(l3_reg),
    .el1_is64(el1_is64), .os_lock(os_lock), .halt_allowed(halt_allowed),
    .ext_trap_dbg(ext_trap),
    .status(status), .exc_class(exc_class), .rdata(rdata));

  function automatic logic [63:0] fmt(input logic [63:0] v);
    logic [63:0] r = '0;
    for (int b = 2; b <= MSB; b++) r[b] = v[b];
    for (int b = MSB + 1; b < 64; b++) r[b] = v[MSB];
    return r;
  endfunction

  function automatic logic [2:0] exp_status();
    if (!(req_valid && sel_op0 == 2 && sel_op1 == 0 && sel_crn == 0 && sel_op2 == 6)) return 0;
    if (cur_el == 0) return 2;
    if (cur_el == 1 && el2_enabled && el2_is64 && (l2_all || l2_reg)) return 3;
    if (cur_el != 3 && el3_present && el3_is64 && l3_reg) return 4;
    if (el1_is64 && !os_lock && halt_allowed && ext_trap) return 5;
    return 1;
  endfunction

  function automatic string tag(input logic [2:0] s);
    case (s)
      0: return "R1"; 1: return "R6"; 2: return "R2";
      3: return "R3"; 4: return "R4"; default: return "R5";
    endcase
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at %0t: actual %h expected %h", req, $time, act, exp);
    end
  endtask

  // called just after a falling edge with inputs driven; compares, then commits the model
  task automatic step();
    logic [2:0] es; logic [63:0] er;
    #2;
    es = exp_status();
    er = (es == 1 && !req_write) ? fmt(mdl[sel_crm]) : 64'd0;
    check(tag(es), {61'd0, status}, {61'd0, es});
    check((es == 3 || es == 4) ? "R4" : "R4 none", {58'd0, exc_class},
          (es == 3 || es == 4) ? 64'h18 : 64'h0);
    check((es == 1 && !req_write) ? "R8" : "R9", rdata, er);
    @(posedge clk);
    if (es == 1 && req_write) mdl[sel_crm] = wdata;
    @(negedge clk);
  endtask

  task automatic perm_clear();
    el2_enabled = 0; el2_is64 = 0; l2_all = 0; l2_reg = 0;
    el3_present = 0; el3_is64 = 0; l3_reg = 0;
    el1_is64 = 0; os_lock = 0; halt_allowed = 0; ext_trap = 0;
    sel_op0 = 2; sel_op1 = 0; sel_crn = 0; sel_op2 = 6;
  endtask

  task automatic acc(input logic wr, input logic [3:0] i, input logic [63:0] d);
    req_valid = 1; req_write = wr; sel_crm = i; wdata = d; step();
    req_valid = 0;
  endtask

  task automatic cold_reset();
    cold_rst_n = 0; #1;
    for (int i = 0; i < 16; i++) mdl[i] = 0;
    @(negedge clk); @(negedge clk); cold_rst_n = 1; @(negedge clk);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      done = 1; fails++; checks++;
      $display("FAIL watchdog expired: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) mdl[i] = 0;
    perm_clear();
    @(negedge clk); @(negedge clk); cold_rst_n = 1; @(negedge clk);
    // R10: reset state
    for (int i = 0; i < 16; i++) acc(0, 4'(i), 0);
    // R6 R7 R8: write patterns, including reserved bits set and msb set/clear
    acc(1, 0, 64'hFFFF_FFFF_FFFF_FFFF); acc(0, 0, 0);
    acc(1, 5, 64'h0010_1234_5678_9ABF); acc(0, 5, 0);
    acc(1, 15, 64'hFFE0_0000_0000_0003); acc(0, 15, 0);
    acc(1, 7, 64'h0008_0000_0000_0004); acc(0, 7, 0);
    // R1: bad selectors write nothing
    sel_op2 = 5; acc(1, 5, 64'h1111); sel_op2 = 6;
    sel_crn = 1; acc(1, 5, 64'h2222); sel_crn = 0;
    sel_op0 = 3; acc(1, 5, 64'h3333); sel_op0 = 2;
    sel_op1 = 1; acc(1, 5, 64'h4444); sel_op1 = 0;
    acc(0, 5, 0);
    // R2..R5 + R9: every condition at each level, faulted write then read
    for (int el = 0; el < 4; el++) begin
      cur_el = 2'(el);
      el2_enabled = 1; el2_is64 = 1; l2_all = 1;
      el3_present = 1; el3_is64 = 1; l3_reg = 1;
      el1_is64 = 1; halt_allowed = 1; ext_trap = 1;
      acc(1, 3, 64'hDEAD_BEEF_0000_0010);
      l2_all = 0; l2_reg = 1; acc(1, 3, 64'hAAAA_0000_0000_0020);
      l2_reg = 0; acc(1, 3, 64'hBBBB_0000_0000_0030);
      l3_reg = 0; acc(1, 3, 64'hCCCC_0000_0000_0040);
      os_lock = 1; acc(1, 3, 64'h0000_0000_0000_0050);
      perm_clear(); cur_el = 1; acc(0, 3, 0);
    end
    // R10: warm reset leaves contents
    acc(1, 9, 64'h0001_5555_AAAA_5554);
    warm_rst_n = 0; @(negedge clk); @(negedge clk); warm_rst_n = 1;
    acc(0, 9, 0);
    // sweep all control inputs
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] r = $urandom;
      {el2_enabled, el2_is64, l2_all, l2_reg, el3_present, el3_is64, l3_reg,
       el1_is64, os_lock, halt_allowed, ext_trap} = r[10:0];
      cur_el = r[12:11];
      sel_op2 = (r[15:13] == 0) ? 3'(r[18:16]) : 3'd6;
      req_valid = r[19]; req_write = r[20]; sel_crm = r[24:21];
      wdata = {$urandom, $urandom};
      step();
    end
    perm_clear(); req_valid = 0; cur_el = 1;
    // R10: cold reset clears
    cold_reset();
    for (int i = 0; i < 16; i++) acc(0, 4'(i), 0);
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule